// File: doc/BRIEF.md
# Inter-Core Doorbell and Mailbox Register Block

This block gives each core of a four-core cluster its own page of memory-mapped registers so that cores can signal one another. A sender writes a bit pattern into the target core's doorbell-set port. The pattern is merged into that core's pending word, and the core's interrupt line is driven high. The receiving core reads its pending word, then writes the bits it has handled into its doorbell-clear port. The interrupt line goes low only when no pending bit is left. Each page also has a free-form 32-bit enable word and four 64-bit mailbox words that carry message payloads. The enable word is stored and can be read back, but it does not gate the interrupt.

Access is through a simple synchronous register bus. It has a 10-bit byte address, separate read and write strobes, 64-bit write and read data, and a size select for 4-byte or 8-byte access. Read data and the error pulse appear on the cycle after the strobe. Misaligned accesses and accesses to offsets with no register are rejected and flagged.

Top module: `ipi_doorbell_regs`

## Requirements
- R1: Address bits [9:8] pick the core page (core n at n*0x100) and bits [7:0] pick the register: 0x00 pending, 0x04 enable, 0x08 doorbell-set, 0x0C doorbell-clear, 0x20/0x28/0x30/0x38 mailbox words. Pages hold independent state.
- R2: A write to doorbell-set ORs write data [31:0] into that core's pending word and drives that core's interrupt high, even when the data is zero.
- R3: A write to doorbell-clear removes the written 1 bits from pending. The interrupt goes low only if the resulting pending word is zero, and otherwise stays high.
- R4: Writes to the pending offset change nothing. Reads of doorbell-set and doorbell-clear return zero.
- R5: The enable word stores write data [31:0] and returns it zero-extended on read. It affects neither the pending word nor any interrupt.
- R6: An 8-byte (bus_wide=1) mailbox write stores all 64 bits, and an 8-byte read returns them.
- R7: Mailbox offsets 0x20..0x3F map linearly and little-endian onto the storage. A 4-byte access at offset bit 2 = 1 touches only the upper half of the word, and at bit 2 = 0 only the lower half. A 4-byte read returns the half in bits [31:0] with zeros above.
- R8: An access whose offset is not a multiple of its size (4 or 8) changes no state, reads as zero, and raises bus_err for exactly one cycle.
- R9: An aligned access to an offset with no register changes no state, reads as zero, and raises bus_err for one cycle.
- R10: bus_rdata and bus_err are registered. They are valid on the cycle after the strobe, and bus_rdata is zero after a cycle with no read.
- R11: Reset clears the pending words, enable words, mailboxes, interrupts, bus_rdata and bus_err.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 10 | Byte address within the window |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wide | input | 1 | 1 = 8-byte access, 0 = 4-byte access |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data, one cycle after bus_rd |
| bus_err | output | 1 | One-cycle pulse for a rejected access |
| core_irq | output | 4 | Per-core level interrupt |

## Verification
The doorbell logic is driven with nonzero set patterns that overlap earlier pending bits, which shows that set merges and does not overwrite. A zero-data set is also sent, which shows that the interrupt is tied to the set write itself and not to pending content. The clear sequence first removes only part of the pending bits and then removes the rest. This shows that the line holds while bits remain and drops exactly at zero. A zero-data clear on an already-empty page shows that the drop depends on the result and not on the data. Mailbox traffic mixes 8-byte and both 4-byte halves across two pages, which separates half selection, byte order and page decode.

// File: rtl/ipi_doorbell_pkg.sv
package ipi_doorbell_pkg;
   typedef enum logic [2:0] {
      RK_NONE,
      RK_PEND,
      RK_ENAB,
      RK_SET,
      RK_CLR,
      RK_MBOX
   } reg_kind_e;

   localparam logic [7:0] OFS_PEND = 8'h00;
   localparam logic [7:0] OFS_ENAB = 8'h04;
   localparam logic [7:0] OFS_SET  = 8'h08;
   localparam logic [7:0] OFS_CLR  = 8'h0C;
   localparam logic [2:0] MBOX_HI3 = 3'b001;  // offsets 0x20..0x3F
endpackage

// File: rtl/ipi_access_decode.sv
module ipi_access_decode
   import ipi_doorbell_pkg::*;
#(
   parameter int PAGE_BITS = 2,
   parameter int OFS_BITS  = 8,
   parameter int MBOX_IDXW = 2,
   localparam int ADDR_W   = PAGE_BITS + OFS_BITS
) (
   input  logic [ADDR_W-1:0]    addr,
   input  logic                 rd,
   input  logic                 wr,
   input  logic                 wide,
   output logic [PAGE_BITS-1:0] page,
   output reg_kind_e            kind,
   output logic [MBOX_IDXW-1:0] mbox_idx,
   output logic                 hi_half,
   output logic                 acc_ok,
   output logic                 acc_bad
);
   logic [OFS_BITS-1:0] ofs;
   logic                aligned;

   generate
      if (OFS_BITS != 8) begin : g_bad_ofs
         $error("ipi_access_decode: OFS_BITS must be 8");
      end
      if (MBOX_IDXW != 2) begin : g_bad_idx
         $error("ipi_access_decode: mailbox region is 32 bytes, MBOX_IDXW must be 2");
      end
   endgenerate

   assign ofs      = addr[OFS_BITS-1:0];
   assign page     = addr[ADDR_W-1:OFS_BITS];
   assign mbox_idx = ofs[4:3];
   assign hi_half  = ofs[2];
   assign aligned  = wide ? (ofs[2:0] == 3'b000) : (ofs[1:0] == 2'b00);

   always_comb begin
      if (ofs[7:5] == MBOX_HI3)  kind = RK_MBOX;
      else if (ofs == OFS_PEND)  kind = RK_PEND;
      else if (ofs == OFS_ENAB)  kind = RK_ENAB;
      else if (ofs == OFS_SET)   kind = RK_SET;
      else if (ofs == OFS_CLR)   kind = RK_CLR;
      else                       kind = RK_NONE;
   end

   assign acc_bad = (rd | wr) & (~aligned | (kind == RK_NONE));
   assign acc_ok  = (rd | wr) & aligned & (kind != RK_NONE);
endmodule

// File: rtl/ipi_core_page.sv
module ipi_core_page
   import ipi_doorbell_pkg::*;
#(
   parameter int STAT_W     = 32,
   parameter int DATA_W     = 64,
   parameter int MBOX_WORDS = 4,
   localparam int IDXW      = $clog2(MBOX_WORDS),
   localparam int HALF_W    = DATA_W / 2
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr_en,
   input  reg_kind_e                    kind,
   input  logic [IDXW-1:0]              mbox_idx,
   input  logic                         hi_half,
   input  logic                         wide,
   input  logic [DATA_W-1:0]            wdata,
   output logic [STAT_W-1:0]            pend_q,
   output logic [STAT_W-1:0]            enab_q,
   output logic [MBOX_WORDS*DATA_W-1:0] mbox_flat,
   output logic                         irq
);
   logic [DATA_W-1:0] mbox_q [MBOX_WORDS];
   logic [STAT_W-1:0] pend_after_clr;
   logic              wr_set, wr_clr;

   generate
      if (STAT_W > HALF_W) begin : g_bad_stat
         $error("ipi_core_page: STAT_W must fit in half the data path");
      end
   endgenerate

   assign wr_set         = wr_en & (kind == RK_SET);
   assign wr_clr         = wr_en & (kind == RK_CLR);
   assign pend_after_clr = pend_q & ~wdata[STAT_W-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= '0;
         enab_q <= '0;
         irq    <= 1'b0;
      end else begin
         if (wr_set) begin
            pend_q <= pend_q | wdata[STAT_W-1:0];
            irq    <= 1'b1;
         end else if (wr_clr) begin
            pend_q <= pend_after_clr;
            if (pend_after_clr == '0) irq <= 1'b0;
         end
         if (wr_en && kind == RK_ENAB) enab_q <= wdata[STAT_W-1:0];
      end
   end

   genvar gw;
   generate
      for (gw = 0; gw < MBOX_WORDS; gw++) begin : g_mbox
         logic hit;
         assign hit = wr_en & (kind == RK_MBOX) & (mbox_idx == IDXW'(gw));
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               mbox_q[gw] <= '0;
            end else if (hit) begin
               if (wide)         mbox_q[gw] <= wdata;
               else if (hi_half) mbox_q[gw][DATA_W-1:HALF_W] <= wdata[HALF_W-1:0];
               else              mbox_q[gw][HALF_W-1:0] <= wdata[HALF_W-1:0];
            end
         end
         assign mbox_flat[gw*DATA_W +: DATA_W] = mbox_q[gw];
      end
   endgenerate

   AST_SET_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
      wr_set |=> irq);  // R2
   AST_RISE_NEEDS_SET: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(wr_set));  // R2
   AST_CLR_PARTIAL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_clr && irq && (pend_after_clr != '0)) |=> irq);  // R3
   AST_DROP_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq) |-> (pend_q == '0));  // R3
   AST_PEND_ONLY_BY_DOORBELL: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_set || wr_clr) |=> $stable(pend_q));  // R4
endmodule

// File: rtl/ipi_doorbell_regs.sv
module ipi_doorbell_regs
   import ipi_doorbell_pkg::*;
#(
   parameter int NUM_CORES  = 4,
   parameter int DATA_W     = 64,
   parameter int STAT_W     = 32,
   parameter int MBOX_WORDS = 4,
   localparam int PAGE_BITS = $clog2(NUM_CORES),
   localparam int OFS_BITS  = 8,
   localparam int ADDR_W    = PAGE_BITS + OFS_BITS,
   localparam int IDXW      = $clog2(MBOX_WORDS),
   localparam int HALF_W    = DATA_W / 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic                 bus_rd,
   input  logic                 bus_wr,
   input  logic                 bus_wide,
   input  logic [DATA_W-1:0]    bus_wdata,
   output logic [DATA_W-1:0]    bus_rdata,
   output logic                 bus_err,
   output logic [NUM_CORES-1:0] core_irq
);
   generate
      if (NUM_CORES != 4) begin : g_bad_cores
         $error("ipi_doorbell_regs: the window holds exactly four pages");
      end
      if (DATA_W != 64) begin : g_bad_data
         $error("ipi_doorbell_regs: data path must be 64 bits");
      end
   endgenerate

   logic [PAGE_BITS-1:0] page;
   reg_kind_e            kind;
   logic [IDXW-1:0]      mbox_idx;
   logic                 hi_half, acc_ok, acc_bad;

   ipi_access_decode #(
      .PAGE_BITS(PAGE_BITS), .OFS_BITS(OFS_BITS), .MBOX_IDXW(IDXW)
   ) u_dec (
      .addr(bus_addr), .rd(bus_rd), .wr(bus_wr), .wide(bus_wide),
      .page(page), .kind(kind), .mbox_idx(mbox_idx), .hi_half(hi_half),
      .acc_ok(acc_ok), .acc_bad(acc_bad)
   );

   logic [STAT_W-1:0]            pend_v [NUM_CORES];
   logic [STAT_W-1:0]            enab_v [NUM_CORES];
   logic [MBOX_WORDS*DATA_W-1:0] mbox_v [NUM_CORES];

   genvar gc;
   generate
      for (gc = 0; gc < NUM_CORES; gc++) begin : g_page
         ipi_core_page #(
            .STAT_W(STAT_W), .DATA_W(DATA_W), .MBOX_WORDS(MBOX_WORDS)
         ) u_page (
            .clk(clk), .rst_n(rst_n),
            .wr_en(bus_wr & acc_ok & (page == PAGE_BITS'(gc))),
            .kind(kind), .mbox_idx(mbox_idx), .hi_half(hi_half),
            .wide(bus_wide), .wdata(bus_wdata),
            .pend_q(pend_v[gc]), .enab_q(enab_v[gc]),
            .mbox_flat(mbox_v[gc]), .irq(core_irq[gc])
         );
      end
   endgenerate

   logic [DATA_W-1:0] mword, rd_mux;

   always_comb begin
      mword  = mbox_v[page][mbox_idx*DATA_W +: DATA_W];
      rd_mux = '0;
      if (bus_rd && acc_ok) begin
         unique case (kind)
            RK_PEND: rd_mux = DATA_W'(pend_v[page]);
            RK_ENAB: rd_mux = DATA_W'(enab_v[page]);
            RK_MBOX: begin
               if (bus_wide)     rd_mux = mword;
               else if (hi_half) rd_mux = DATA_W'(mword[DATA_W-1:HALF_W]);
               else              rd_mux = DATA_W'(mword[HALF_W-1:0]);
            end
            default: rd_mux = '0;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bus_rdata <= '0;
         bus_err   <= 1'b0;
      end else begin
         bus_rdata <= rd_mux;
         bus_err   <= acc_bad;
      end
   end

   AST_BAD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && acc_bad) |=> (bus_rdata == '0));  // R9
   AST_ERR_ONLY_ON_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_rd || bus_wr) |=> !bus_err);  // R8
   AST_IDLE_RDATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> (bus_rdata == '0));  // R10
   AST_DOORBELL_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && (kind == RK_SET || kind == RK_CLR)) |=> (bus_rdata == '0));  // R4
endmodule

// File: tb/tb_ipi_doorbell_regs.sv
`timescale 1ns/1ps
module tb_ipi_doorbell_regs;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [9:0]  bus_addr = '0;
   logic        bus_rd = 1'b0, bus_wr = 1'b0, bus_wide = 1'b0;
   logic [63:0] bus_wdata = '0;
   logic [63:0] bus_rdata;
   logic        bus_err;
   logic [3:0]  core_irq;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   ipi_doorbell_regs dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
      .bus_wr(bus_wr), .bus_wide(bus_wide), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .bus_err(bus_err), .core_irq(core_irq)
   );

   typedef struct packed {
      logic        rd;
      logic        wr;
      logic        wide;
      logic [9:0]  addr;
      logic [63:0] wd;
      logic [63:0] exp_rd;
      logic [3:0]  exp_irq;
      logic        exp_err;
      logic [7:0]  req;
   } vec_t;

   localparam int NV = 32;
   localparam vec_t VEC [NV] = '{
      '{1'b1,1'b0,1'b0,10'h000,64'h0,64'h0,4'b0000,1'b0,8'd11},                                      // R11 pending zero
      '{1'b0,1'b1,1'b0,10'h108,64'h5,64'h0,4'b0010,1'b0,8'd2},                                       // R2 set raises
      '{1'b1,1'b0,1'b0,10'h100,64'h0,64'h5,4'b0010,1'b0,8'd2},                                       // R2
      '{1'b0,1'b1,1'b0,10'h108,64'h8,64'h0,4'b0010,1'b0,8'd2},                                       // R2 merge
      '{1'b1,1'b0,1'b0,10'h100,64'h0,64'hD,4'b0010,1'b0,8'd2},                                       // R2
      '{1'b0,1'b1,1'b0,10'h10C,64'h4,64'h0,4'b0010,1'b0,8'd3},                                       // R3 partial clear
      '{1'b1,1'b0,1'b0,10'h100,64'h0,64'h9,4'b0010,1'b0,8'd3},                                       // R3
      '{1'b0,1'b1,1'b0,10'h10C,64'h9,64'h0,4'b0000,1'b0,8'd3},                                       // R3 drop at zero
      '{1'b1,1'b0,1'b0,10'h100,64'h0,64'h0,4'b0000,1'b0,8'd3},                                       // R3
      '{1'b0,1'b1,1'b0,10'h000,64'hFF,64'h0,4'b0000,1'b0,8'd4},                                      // R4 pending write
      '{1'b1,1'b0,1'b0,10'h000,64'h0,64'h0,4'b0000,1'b0,8'd4},                                       // R4
      '{1'b0,1'b1,1'b0,10'h308,64'h0,64'h0,4'b1000,1'b0,8'd2},                                       // R2 zero-data set
      '{1'b1,1'b0,1'b0,10'h308,64'h0,64'h0,4'b1000,1'b0,8'd4},                                       // R4 set reads 0
      '{1'b1,1'b0,1'b0,10'h30C,64'h0,64'h0,4'b1000,1'b0,8'd4},                                       // R4 clr reads 0
      '{1'b0,1'b1,1'b0,10'h204,64'hFFFF_FFFF_1234_5678,64'h0,4'b1000,1'b0,8'd5},                     // R5
      '{1'b1,1'b0,1'b0,10'h204,64'h0,64'h1234_5678,4'b1000,1'b0,8'd5},                               // R5
      '{1'b0,1'b1,1'b1,10'h020,64'h1122_3344_5566_7788,64'h0,4'b1000,1'b0,8'd6},                     // R6
      '{1'b1,1'b0,1'b1,10'h020,64'h0,64'h1122_3344_5566_7788,4'b1000,1'b0,8'd6},                     // R6
      '{1'b0,1'b1,1'b0,10'h024,64'hAAAA_BBBB_CCCC_DDDD,64'h0,4'b1000,1'b0,8'd7},                     // R7 upper half
      '{1'b1,1'b0,1'b1,10'h020,64'h0,64'hCCCC_DDDD_5566_7788,4'b1000,1'b0,8'd7},                     // R7
      '{1'b1,1'b0,1'b0,10'h020,64'h0,64'h5566_7788,4'b1000,1'b0,8'd7},                               // R7 lower read
      '{1'b0,1'b1,1'b1,10'h238,64'hDEAD_BEEF_00C0_FFEE,64'h0,4'b1000,1'b0,8'd6},                     // R6
      '{1'b1,1'b0,1'b1,10'h238,64'h0,64'hDEAD_BEEF_00C0_FFEE,4'b1000,1'b0,8'd6},                     // R6
      '{1'b1,1'b0,1'b1,10'h038,64'h0,64'h0,4'b1000,1'b0,8'd1},                                       // R1 pages separate
      '{1'b0,1'b1,1'b1,10'h024,64'h0,64'h0,4'b1000,1'b1,8'd8},                                       // R8 misaligned wr
      '{1'b1,1'b0,1'b1,10'h020,64'h0,64'hCCCC_DDDD_5566_7788,4'b1000,1'b0,8'd8},                     // R8 untouched
      '{1'b1,1'b0,1'b0,10'h022,64'h0,64'h0,4'b1000,1'b1,8'd8},                                       // R8 misaligned rd
      '{1'b0,1'b1,1'b0,10'h010,64'h1,64'h0,4'b1000,1'b1,8'd9},                                       // R9 unmapped wr
      '{1'b1,1'b0,1'b0,10'h010,64'h0,64'h0,4'b1000,1'b1,8'd9},                                       // R9 unmapped rd
      '{1'b1,1'b0,1'b1,10'h040,64'h0,64'h0,4'b1000,1'b1,8'd9},                                       // R9
      '{1'b0,1'b1,1'b0,10'h30C,64'h0,64'h0,4'b0000,1'b0,8'd3},                                       // R3 empty clear drops
      '{1'b0,1'b0,1'b0,10'h000,64'h0,64'h0,4'b0000,1'b0,8'd10}                                       // R10 idle
   };

   task automatic chk(input int req, input string what, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic drive(input logic rd, input logic wr, input logic wide,
                        input logic [9:0] a, input logic [63:0] wd);
      bus_rd = rd; bus_wr = wr; bus_wide = wide; bus_addr = a; bus_wdata = wd;
      @(negedge clk);
      bus_rd = 1'b0; bus_wr = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL R10 watchdog actual=timeout expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R11: outputs cleared during reset
      chk(11, "irq in reset", 64'(core_irq), 64'h0);
      chk(11, "err in reset", 64'(bus_err), 64'h0);
      chk(11, "rdata in reset", bus_rdata, 64'h0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         drive(VEC[i].rd, VEC[i].wr, VEC[i].wide, VEC[i].addr, VEC[i].wd);
         chk(int'(VEC[i].req), $sformatf("vec%0d rdata", i), bus_rdata, VEC[i].exp_rd);
         chk(int'(VEC[i].req), $sformatf("vec%0d irq", i), 64'(core_irq), 64'(VEC[i].exp_irq));
         chk(int'(VEC[i].req), $sformatf("vec%0d err", i), 64'(bus_err), 64'(VEC[i].exp_err));
      end

      // R8: error is a single-cycle pulse
      drive(1'b1, 1'b0, 1'b1, 10'h104, 64'h0);
      chk(8, "err pulse high", 64'(bus_err), 64'h1);
      @(negedge clk);
      chk(8, "err pulse low", 64'(bus_err), 64'h0);

      // R5: enable all ones on core0 does not raise its interrupt
      drive(1'b0, 1'b1, 1'b0, 10'h004, 64'hFFFF_FFFF);
      chk(5, "enable no irq", 64'(core_irq), 64'h0);
      drive(1'b1, 1'b0, 1'b0, 10'h000, 64'h0);
      chk(5, "enable no pending", bus_rdata, 64'h0);

      // R11: reset mid-run clears live state
      drive(1'b0, 1'b1, 1'b0, 10'h008, 64'h3);
      chk(11, "irq before reset", 64'(core_irq), 64'h1);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      chk(11, "irq after reset", 64'(core_irq), 64'h0);
      drive(1'b1, 1'b0, 1'b0, 10'h000, 64'h0);
      chk(11, "pending after reset", bus_rdata, 64'h0);
      drive(1'b1, 1'b0, 1'b1, 10'h238, 64'h0);
      chk(11, "mailbox after reset", bus_rdata, 64'h0);
      drive(1'b1, 1'b0, 1'b0, 10'h004, 64'h0);
      chk(11, "enable after reset", bus_rdata, 64'h0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule